// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Bridge

The bridge sits between a 16-bit peripheral and system memory and moves one transfer at a time. A transfer request carries a peripheral offset, a byte length, a direction and a flag that bypasses swapping. The bridge builds the memory address by a bitwise OR of the offset with a base value; it does not add them. It then issues one or more memory commands and streams 16-bit beats between the memory data ports and the peripheral data ports.

In swap mode, which is the default, the two bytes of every halfword are exchanged in both directions. Bit 0 of the address and of the length is cleared before the transfer. Writes to memory are split into commands of at most `CHUNK_BYTES` bytes, and the address advances by each command's length. With the bypass flag set, data passes unchanged, and the address and length are used exactly as given. A done pulse closes every accepted request.

Top module: `hwsb_bridge`

## Requirements
- R1: The first memory command address is `base_addr | req_offset`, with bit 0 then cleared in swap mode. It is never the arithmetic sum of the two.
- R2: With `req_noswap`=1, the command address and length equal the requested ones, including odd values, and each data beat passes with its bytes unchanged.
- R3: With `req_noswap`=0, the command address and length have bit 0 cleared, so a requested length of 9 moves 8 bytes.
- R4: In swap mode with `req_write`=0 (memory to peripheral), `per_out_data` is the memory beat with bits [15:8] and [7:0] exchanged.
- R5: In swap mode with `req_write`=1 (peripheral to memory), `mem_wr_data` is the peripheral beat with bits [15:8] and [7:0] exchanged.
- R6: In swap mode a write is issued as consecutive commands of `CHUNK_BYTES` (64) bytes followed by a remainder. Each command address is the previous address plus the previous length.
- R7: Reads, and writes in bypass mode, use exactly one memory command for the whole length, with `mem_cmd_write` equal to `req_write`.
- R8: A length that is zero after alignment issues no memory command and still produces the done pulse.
- R9: `req_ready` is high only while idle. `done` is a single-cycle pulse after the last beat of a transfer.
- R10: After reset, `req_ready`=1, and `mem_cmd_valid`=0, `done`=0.
- R11: Each command moves ceil(length/2) beats, and a command that is not accepted holds its address and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | AW | Base value ORed into the offset; sampled when a request is accepted |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Bridge idle and accepting a request |
| req_offset | input | AW | Peripheral-supplied address offset |
| req_len | input | LW | Transfer length in bytes |
| req_write | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_noswap | input | 1 | 1: bypass the halfword byte swap |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory command accepted |
| mem_cmd_addr | output | AW | Memory command byte address |
| mem_cmd_len | output | LW | Memory command byte length |
| mem_cmd_write | output | 1 | Memory command direction (1 = write) |
| mem_rd_valid | input | 1 | Memory read beat valid |
| mem_rd_ready | output | 1 | Bridge takes a memory read beat |
| mem_rd_data | input | DW | Memory read beat |
| per_out_valid | output | 1 | Beat to the peripheral valid |
| per_out_ready | input | 1 | Peripheral takes a beat |
| per_out_data | output | DW | Beat to the peripheral |
| per_in_valid | input | 1 | Beat from the peripheral valid |
| per_in_ready | output | 1 | Bridge takes a peripheral beat |
| per_in_data | input | DW | Beat from the peripheral |
| mem_wr_valid | output | 1 | Memory write beat valid |
| mem_wr_ready | input | 1 | Memory takes a write beat |
| mem_wr_data | output | DW | Memory write beat |

## Verification
The assertions assume that memory returns exactly ceil(length/2) read beats for each accepted read command. They also assume that the peripheral supplies exactly that many beats for a write and that `req_len` fits in `LW` bits. The bench models memory so that it produces read beats only as a count released by accepted read commands. It loads the peripheral queue with exactly the number of beats a transfer needs. The ready and valid signals on each side toggle in unrelated cycle patterns, which exercises stalls without ever breaking that beat contract.

// File: rtl/hwsb_pkg.sv
package hwsb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_BEAT = 2'd2,
        ST_FIN  = 2'd3
    } hwsb_state_e;

endpackage

// File: rtl/hwsb_lane.sv
// Halfword byte-exchange lane: each 16-bit group of the beat has its bytes
// swapped when swap_en is set, otherwise the beat passes unchanged.
module hwsb_lane #(
    parameter int DW = 16
) (
    input  logic          swap_en,
    input  logic [DW-1:0] in_data,
    output logic [DW-1:0] out_data
);
    localparam int HALVES = DW / 16;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_comb begin
            if (swap_en) begin
                out_data[h*16 +: 8]     = in_data[h*16 + 8 +: 8];
                out_data[h*16 + 8 +: 8] = in_data[h*16 +: 8];
            end else begin
                out_data[h*16 +: 16]    = in_data[h*16 +: 16];
            end
        end
    end

endmodule

// File: rtl/hwsb_align.sv
// Request front end: OR-combines base and offset, forces both address and
// length even in swap mode, flags an empty transfer.
module hwsb_align #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] offset,
    input  logic [LW-1:0] len_in,
    input  logic          swap_en,
    output logic [AW-1:0] addr_out,
    output logic [LW-1:0] len_out,
    output logic          is_empty
);
    logic [AW-1:0] merged;

    always_comb begin
        merged   = base_addr | offset;
        addr_out = swap_en ? {merged[AW-1:1], 1'b0} : merged;
        len_out  = swap_en ? {len_in[LW-1:1], 1'b0} : len_in;
        is_empty = (len_out == '0);
    end

endmodule

// File: rtl/hwsb_chunk.sv
// Command sizer: caps the command length at CHUNK_BYTES when limiting is on.
module hwsb_chunk #(
    parameter int LW          = 16,
    parameter int CHUNK_BYTES = 64
) (
    input  logic [LW-1:0] remain,
    input  logic          limit_en,
    output logic [LW-1:0] cmd_len
);
    localparam logic [LW-1:0] CAP = LW'(CHUNK_BYTES);

    always_comb begin
        if (limit_en && (remain > CAP)) cmd_len = CAP;
        else                            cmd_len = remain;
    end

endmodule

// File: rtl/hwsb_bridge.sv
module hwsb_bridge
    import hwsb_pkg::*;
#(
    parameter int AW          = 32,
    parameter int LW          = 16,
    parameter int DW          = 16,
    parameter int CHUNK_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_addr,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_offset,
    input  logic [LW-1:0] req_len,
    input  logic          req_write,
    input  logic          req_noswap,
    output logic          done,
    output logic          mem_cmd_valid,
    input  logic          mem_cmd_ready,
    output logic [AW-1:0] mem_cmd_addr,
    output logic [LW-1:0] mem_cmd_len,
    output logic          mem_cmd_write,
    input  logic          mem_rd_valid,
    output logic          mem_rd_ready,
    input  logic [DW-1:0] mem_rd_data,
    output logic          per_out_valid,
    input  logic          per_out_ready,
    output logic [DW-1:0] per_out_data,
    input  logic          per_in_valid,
    output logic          per_in_ready,
    input  logic [DW-1:0] per_in_data,
    output logic          mem_wr_valid,
    input  logic          mem_wr_ready,
    output logic [DW-1:0] mem_wr_data
);
    localparam int BYTES_PER_BEAT = DW / 8;

    typedef struct packed {
        hwsb_state_e   st;
        logic [AW-1:0] addr;
        logic [LW-1:0] remain;
        logic [LW-1:0] beats;
        logic          wr;
        logic          swap;
    } xfer_t;

    xfer_t q, d;

    logic [AW-1:0] al_addr;
    logic [LW-1:0] al_len;
    logic          al_empty;
    logic [LW-1:0] chunk_len;
    logic          beat_go;

    hwsb_align #(.AW(AW), .LW(LW)) u_align (
        .base_addr (base_addr),
        .offset    (req_offset),
        .len_in    (req_len),
        .swap_en   (!req_noswap),
        .addr_out  (al_addr),
        .len_out   (al_len),
        .is_empty  (al_empty)
    );

    hwsb_chunk #(.LW(LW), .CHUNK_BYTES(CHUNK_BYTES)) u_chunk (
        .remain   (q.remain),
        .limit_en (q.swap && q.wr),
        .cmd_len  (chunk_len)
    );

    hwsb_lane #(.DW(DW)) u_lane_rd (
        .swap_en  (q.swap),
        .in_data  (mem_rd_data),
        .out_data (per_out_data)
    );

    hwsb_lane #(.DW(DW)) u_lane_wr (
        .swap_en  (q.swap),
        .in_data  (per_in_data),
        .out_data (mem_wr_data)
    );

    always_comb begin
        d             = q;
        req_ready     = 1'b0;
        done          = 1'b0;
        mem_cmd_valid = 1'b0;
        mem_cmd_addr  = q.addr;
        mem_cmd_len   = chunk_len;
        mem_cmd_write = q.wr;
        mem_rd_ready  = 1'b0;
        per_out_valid = 1'b0;
        per_in_ready  = 1'b0;
        mem_wr_valid  = 1'b0;
        beat_go       = 1'b0;

        case (q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    d.addr   = al_addr;
                    d.remain = al_len;
                    d.wr     = req_write;
                    d.swap   = !req_noswap;
                    d.beats  = '0;
                    d.st     = al_empty ? ST_FIN : ST_CMD;
                end
            end
            ST_CMD: begin
                mem_cmd_valid = 1'b1;
                if (mem_cmd_ready) begin
                    d.beats  = LW'(({1'b0, chunk_len} + (LW+1)'(BYTES_PER_BEAT - 1))
                                   / (LW+1)'(BYTES_PER_BEAT));
                    d.remain = q.remain - chunk_len;
                    d.addr   = q.addr + AW'(chunk_len);
                    d.st     = ST_BEAT;
                end
            end
            ST_BEAT: begin
                if (q.wr) begin
                    mem_wr_valid = per_in_valid;
                    per_in_ready = mem_wr_ready;
                    beat_go      = per_in_valid && mem_wr_ready;
                end else begin
                    per_out_valid = mem_rd_valid;
                    mem_rd_ready  = per_out_ready;
                    beat_go       = mem_rd_valid && per_out_ready;
                end
                if (beat_go) begin
                    d.beats = q.beats - 1'b1;
                    if (q.beats == LW'(1)) begin
                        d.st = (q.remain == '0) ? ST_FIN : ST_CMD;
                    end
                end
            end
            default: begin
                done = 1'b1;
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.addr   <= '0;
            q.remain <= '0;
            q.beats  <= '0;
            q.wr     <= 1'b0;
            q.swap   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R3: in swap mode every command is halfword aligned in address and size
    a_r3_even_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && q.swap) |-> (!mem_cmd_addr[0] && !mem_cmd_len[0]));

    // R6: swap-mode write commands never exceed the chunk size
    a_r6_chunk_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && mem_cmd_write && q.swap) |-> (mem_cmd_len <= LW'(CHUNK_BYTES)));

    // R8: no command of zero length reaches memory
    a_r8_no_empty_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> (mem_cmd_len != '0));

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a request is taken once; the bridge is busy on the next cycle
    a_r9_accept_once: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11: a pending command holds still until accepted
    a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && !mem_cmd_ready) |=>
            (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len)));

    // R9: data beats only move while no command is outstanding
    a_r9_beat_excl: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> !(mem_wr_valid || per_out_valid || per_in_ready || mem_rd_ready));

endmodule

// File: tb/tb_hwsb_bridge.sv
module tb_hwsb_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_offset = '0;
    logic [15:0] req_len = '0;
    logic        req_write = 1'b0;
    logic        req_noswap = 1'b0;
    logic        done;
    logic        mem_cmd_valid, mem_cmd_ready = 1'b0;
    logic [31:0] mem_cmd_addr;
    logic [15:0] mem_cmd_len;
    logic        mem_cmd_write;
    logic        mem_rd_valid = 1'b0, mem_rd_ready;
    logic [15:0] mem_rd_data = '0;
    logic        per_out_valid, per_out_ready = 1'b0;
    logic [15:0] per_out_data;
    logic        per_in_valid = 1'b0, per_in_ready;
    logic [15:0] per_in_data = '0;
    logic        mem_wr_valid, mem_wr_ready = 1'b0;
    logic [15:0] mem_wr_data;

    always #2 clk = ~clk;

    hwsb_bridge dut (.*);

    int checks = 0, fails = 0;
    int cyc = 0;
    int rd_left = 0;
    int rd_gen_seq = 0, rd_exp_seq = 0, wr_seq = 0;
    int done_cnt = 0, cmd_cnt = 0;
    logic prev_done = 1'b0;

    logic [48:0] exp_cmd_q[$];
    logic [15:0] exp_pout_q[$];
    logic [15:0] exp_mwr_q[$];
    logic [15:0] per_in_q[$];

    function automatic logic [15:0] mem_word(int s);
        return 16'h1234 ^ 16'(s * 16'h0707);
    endfunction

    function automatic logic [15:0] per_word(int s);
        return 16'hC35A + 16'(s * 16'h0123);
    endfunction

    function automatic logic [15:0] bswap(logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Stimulus generator for the ready/valid patterns and memory read beats
    always @(posedge clk) begin
        #1;
        cyc++;
        mem_cmd_ready = (cyc % 3) != 0;
        per_out_ready = (cyc % 4) != 1;
        mem_wr_ready  = (cyc % 5) != 2;
        mem_rd_valid  = (rd_left > 0) && ((cyc % 7) != 3);
        mem_rd_data   = mem_word(rd_gen_seq);
        per_in_valid  = (per_in_q.size() > 0) && ((cyc % 3) != 1);
        per_in_data   = (per_in_q.size() > 0) ? per_in_q[0] : 16'h0;
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) check(0, "R9", "done longer than one cycle", 1, 0);
            prev_done = done;
            if (done) done_cnt++;
            if (mem_cmd_valid && mem_cmd_ready) begin
                cmd_cnt++;
                if (exp_cmd_q.size() == 0) begin
                    check(0, "R8", "unexpected command", {15'b0, mem_cmd_write, mem_cmd_len, mem_cmd_addr}, 0);
                end else begin
                    logic [48:0] e;
                    e = exp_cmd_q.pop_front();
                    check({mem_cmd_write, mem_cmd_len, mem_cmd_addr} == e, "R1/R6/R7", "command",
                          {15'b0, mem_cmd_write, mem_cmd_len, mem_cmd_addr}, {15'b0, e});
                end
                if (!mem_cmd_write) rd_left += (int'(mem_cmd_len) + 1) / 2;
            end
            if (mem_rd_valid && mem_rd_ready) begin
                rd_gen_seq++;
                rd_left--;
            end
            if (per_out_valid && per_out_ready) begin
                if (exp_pout_q.size() == 0) check(0, "R11", "extra peripheral beat", per_out_data, 0);
                else begin
                    logic [15:0] e;
                    e = exp_pout_q.pop_front();
                    check(per_out_data == e, "R4/R2", "peripheral beat", per_out_data, e);
                end
            end
            if (per_in_valid && per_in_ready) void'(per_in_q.pop_front());
            if (mem_wr_valid && mem_wr_ready) begin
                if (exp_mwr_q.size() == 0) check(0, "R11", "extra memory write beat", mem_wr_data, 0);
                else begin
                    logic [15:0] e;
                    e = exp_mwr_q.pop_front();
                    check(mem_wr_data == e, "R5/R2", "memory write beat", mem_wr_data, e);
                end
            end
        end
    end

    // Driver: computes expected items, pushes them, issues the request
    task automatic run_xfer(input logic [31:0] base, input logic [31:0] off, input logic [15:0] len,
                            input bit wr, input bit noswap, input string tag);
        logic [31:0] ea;
        logic [15:0] el;
        int nb, start_done, to, start_cmd;
        ea = base | off;
        el = len;
        if (!noswap) begin
            ea[0] = 1'b0;
            el[0] = 1'b0;
        end
        nb = (int'(el) + 1) / 2;
        if (el != 0) begin
            if (wr && !noswap) begin
                int rem = int'(el);
                logic [31:0] a = ea;
                while (rem > 0) begin
                    int c = (rem > 64) ? 64 : rem;
                    exp_cmd_q.push_back({1'b1, 16'(c), a});
                    a = a + 32'(c);
                    rem -= c;
                end
            end else begin
                exp_cmd_q.push_back({wr, el, ea});
            end
            for (int i = 0; i < nb; i++) begin
                if (wr) begin
                    logic [15:0] w = per_word(wr_seq);
                    wr_seq++;
                    per_in_q.push_back(w);
                    exp_mwr_q.push_back(noswap ? w : bswap(w));
                end else begin
                    logic [15:0] m = mem_word(rd_exp_seq);
                    rd_exp_seq++;
                    exp_pout_q.push_back(noswap ? m : bswap(m));
                end
            end
        end
        start_done = done_cnt;
        start_cmd  = cmd_cnt;
        @(posedge clk); #1;
        base_addr  = base;
        req_offset = off;
        req_len    = len;
        req_write  = wr;
        req_noswap = noswap;
        req_valid  = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b0, "R9", {tag, " ready low while busy"}, req_ready, 0);
        to = 0;
        while (done_cnt == start_done && to < 3000) begin
            @(negedge clk);
            to++;
        end
        check(done_cnt == start_done + 1, "R9", {tag, " done pulse"}, done_cnt - start_done, 1);
        check(exp_cmd_q.size() == 0, "R6/R7", {tag, " commands left"}, exp_cmd_q.size(), 0);
        check(exp_pout_q.size() == 0 && exp_mwr_q.size() == 0, "R11", {tag, " beats left"},
              exp_pout_q.size() + exp_mwr_q.size(), 0);
        if (el == 0) check(cmd_cnt == start_cmd, "R8", {tag, " no command"}, cmd_cnt - start_cmd, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R10", "reset req_ready", req_ready, 1);
        check(mem_cmd_valid == 1'b0, "R10", "reset mem_cmd_valid", mem_cmd_valid, 0);
        check(done == 1'b0, "R10", "reset done", done, 0);

        run_xfer(32'h1000_0010, 32'h0000_0030, 16'd10, 1'b0, 1'b0, "R1 OR address, R4 swap read");
        run_xfer(32'h2000_0000, 32'h0000_0101, 16'd7,  1'b0, 1'b1, "R2 bypass odd read");
        run_xfer(32'h0000_0001, 32'h0000_0040, 16'd9,  1'b0, 1'b0, "R3 forced even read");
        run_xfer(32'h3000_0000, 32'h0000_0201, 16'd150, 1'b1, 1'b0, "R5 R6 chunked swap write");
        run_xfer(32'h3000_0000, 32'h0000_0201, 16'd150, 1'b1, 1'b1, "R7 bypass write single");
        run_xfer(32'h4000_0100, 32'h0000_0002, 16'd128, 1'b1, 1'b0, "R6 exact two chunks");
        run_xfer(32'h4000_0000, 32'h0000_0080, 16'd64,  1'b1, 1'b0, "R6 one full chunk");
        run_xfer(32'h5000_0000, 32'h0000_0003, 16'd1,   1'b1, 1'b0, "R8 len one aligns to zero");
        run_xfer(32'h5000_0000, 32'h0000_0004, 16'd0,   1'b0, 1'b1, "R8 zero bypass");
        run_xfer(32'h6000_0000, 32'h0000_0010, 16'd200, 1'b0, 1'b0, "R7 long read single");
        run_xfer(32'h6000_0000, 32'h0000_0011, 16'd3,   1'b1, 1'b1, "R2 bypass odd write");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule